// File: doc/BRIEF.md
# Wrapping Return Stack

A small last-in, first-out store that a processor core uses as one of its registers. A register write pushes a data word onto the stack. A register read pops one word off. The stack has a fixed depth of six entries by default, and its pointer is visible as an output. When a push finds the stack already full, or a pop finds it empty, the block does not stall and does not saturate. It wraps the pointer. Overflow restarts storage at entry zero. Underflow lands on the topmost entry. In both cases a one-cycle flag reports the event.

The core drives at most one of push or pop per cycle. If both arrive together, the push is carried out and the pop is dropped. A popped word appears on the read data output one clock after the pop, and it stays there until the next pop. The block has no program-counter logic and no instruction decode. It holds only the entries, the pointer and the wrap sequencing.

Top module: `wret_stack`

## Requirements
- R1: After reset, the pointer output is 0, both event flags are low and the read data output is 0.
- R2: A push with the pointer below the depth (6) writes the data into the entry at the pointer, and the pointer then reads one higher in the next cycle.
- R3: A push with the pointer equal to the depth first restarts the pointer at 0. The data goes into entry 0, the pointer then reads 1, and the overflow flag is high for the cycle after the push.
- R4: A pop with a nonzero pointer lowers the pointer by one. In the next cycle the read data output holds the entry at the lowered pointer.
- R5: A pop with the pointer at 0 sets the pointer to depth minus one (5). The read data output then holds entry 5, and the underflow flag is high for the cycle after the pop.
- R6: When push and pop are both asserted in one cycle, only the push takes effect: the pointer moves as for a push, and the read data output keeps its previous value.
- R7: In a cycle with neither push nor pop, the pointer, the stored entries and the read data output keep their values.
- R8: The overflow and underflow flags are single-cycle pulses. Each is low in any cycle that does not follow the matching wrap event, and the two flags are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push request (register write) |
| pop_i | input | 1 | Pop request (register read) |
| push_data_i | input | 16 | Word to push |
| pop_data_o | output | 16 | Word returned by the most recent pop |
| sp_o | output | 3 | Current stack pointer, 0 to 6 |
| ovf_o | output | 1 | Overflow pulse, one cycle after a wrapping push |
| unf_o | output | 1 | Underflow pulse, one cycle after a wrapping pop |

## Verification
The embedded properties watch the pointer on every cycle. They check that it stays within 0 to the depth, that it steps by exactly one on an ordinary push or pop, that it wraps to 1 or 5 with the matching flag, and that it holds when the core is idle. They also check that the read data register changes only on a pop and that the two flags are never high together. What the properties cannot show is that the right word comes back. The entry written on a push, the entry returned after an underflow and the survival of old entries across wraps are all shown only by the bench's scenarios. The bench covers those with directed wrap sequences and a long pseudo-random sweep compared against an arithmetic model.

// File: rtl/wstk_pkg.sv
package wstk_pkg;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_PUSH = 2'd1,
      OP_POP  = 2'd2
   } stk_op_e;

   // push wins over pop when both are requested
   function automatic stk_op_e resolve_op(input logic push, input logic pop);
      if (push)     return OP_PUSH;
      else if (pop) return OP_POP;
      else          return OP_NONE;
   endfunction

endpackage

// File: rtl/wstk_ptr.sv
module wstk_ptr
   import wstk_pkg::*;
#(
   parameter int DEPTH = 6,
   parameter int PW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  stk_op_e       op,
   output logic [PW-1:0] ptr_q,
   output logic [PW-1:0] acc_idx,
   output logic          wr_en,
   output logic          rd_en,
   output logic          ovf_q,
   output logic          unf_q
);

   localparam logic [PW-1:0] TOP  = PW'(DEPTH);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
   localparam logic [PW-1:0] ONE  = PW'(1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("wstk_ptr: DEPTH must be at least 2");
      end
      if (PW < $clog2(DEPTH + 1)) begin : g_bad_pw
         $error("wstk_ptr: PW too narrow for DEPTH");
      end
   endgenerate

   logic [PW-1:0] ptr_d;
   logic          ovf_d, unf_d;

   always_comb begin
      ptr_d   = ptr_q;
      acc_idx = ptr_q;
      wr_en   = 1'b0;
      rd_en   = 1'b0;
      ovf_d   = 1'b0;
      unf_d   = 1'b0;
      unique case (op)
         OP_PUSH: begin
            wr_en = 1'b1;
            if (ptr_q >= TOP) begin
               acc_idx = '0;
               ovf_d   = 1'b1;
            end
            ptr_d = acc_idx + ONE;
         end
         OP_POP: begin
            rd_en = 1'b1;
            if (ptr_q == '0) begin
               acc_idx = LAST;
               unf_d   = 1'b1;
            end else begin
               acc_idx = ptr_q - ONE;
            end
            ptr_d = acc_idx;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
         ovf_q <= 1'b0;
         unf_q <= 1'b0;
      end else begin
         ptr_q <= ptr_d;
         ovf_q <= ovf_d;
         unf_q <= unf_d;
      end
   end

   // R2: pointer never leaves 0..DEPTH
   p_ptr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= TOP);

   // R2: ordinary push steps the pointer up by one
   p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_PUSH && ptr_q < TOP) |=> (ptr_q == $past(ptr_q) + ONE) && !ovf_q);

   // R3: full push restarts at entry 0
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_PUSH && ptr_q == TOP) |=> (ptr_q == ONE) && ovf_q);

   // R4: ordinary pop steps the pointer down by one
   p_pop_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_POP && ptr_q != '0) |=> (ptr_q == $past(ptr_q) - ONE) && !unf_q);

   // R5: empty pop wraps to the top entry
   p_underflow_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_POP && ptr_q == '0) |=> (ptr_q == LAST) && unf_q);

   // R7: idle holds the pointer and keeps flags low
   p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_NONE) |=> $stable(ptr_q) && !ovf_q && !unf_q);

   // R8: flags are exclusive
   p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf_q && unf_q));

endmodule

// File: rtl/wstk_mem.sv
module wstk_mem #(
   parameter int DEPTH = 6,
   parameter int WIDTH = 16,
   parameter int PW    = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [PW-1:0]    idx,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] rdata_q
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("wstk_mem: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] ent [DEPTH];

   // one write-enabled register per entry
   for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      always_ff @(posedge clk) begin
         if (wr_en && idx == PW'(g)) ent[g] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata_q <= '0;
      else if (rd_en) rdata_q <= ent[idx];
   end

   // R6/R7: read data moves only on a pop
   p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata_q));

   // R6: read and write never in one cycle
   p_rw_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && wr_en));

endmodule

// File: rtl/wret_stack.sv
module wret_stack
   import wstk_pkg::*;
#(
   parameter int DEPTH = 6,
   parameter int WIDTH = 16,
   localparam int PW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic             pop_i,
   input  logic [WIDTH-1:0] push_data_i,
   output logic [WIDTH-1:0] pop_data_o,
   output logic [PW-1:0]    sp_o,
   output logic             ovf_o,
   output logic             unf_o
);

   stk_op_e       op;
   logic [PW-1:0] acc_idx;
   logic          wr_en, rd_en;

   assign op = resolve_op(push_i, pop_i);

   wstk_ptr #(.DEPTH(DEPTH), .PW(PW)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .op      (op),
      .ptr_q   (sp_o),
      .acc_idx (acc_idx),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .ovf_q   (ovf_o),
      .unf_q   (unf_o)
   );

   wstk_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PW(PW)) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .idx     (acc_idx),
      .wdata   (push_data_i),
      .rdata_q (pop_data_o)
   );

   // R6: a simultaneous pop is dropped
   p_push_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && pop_i) |=> $stable(pop_data_o) && !unf_o);

endmodule

// File: tb/tb_wret_stack.sv
`timescale 1ns/1ps
module tb_wret_stack;

   localparam int DEPTH = 6;
   localparam int WIDTH = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             push = 1'b0, pop = 1'b0;
   logic [WIDTH-1:0] din = '0;
   logic [WIDTH-1:0] dout;
   logic [2:0]       sp;
   logic             ovf, unf;

   always #2 clk = ~clk;

   wret_stack #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
      .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop),
      .push_data_i(din), .pop_data_o(dout), .sp_o(sp),
      .ovf_o(ovf), .unf_o(unf)
   );

   int checks = 0;
   int errors = 0;

   logic [WIDTH-1:0] mdl [DEPTH];
   int               mptr  = 0;
   logic [WIDTH-1:0] mdata = '0;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // called at a negedge; applies one operation and checks after the edge
   task automatic step(input bit pu, input bit po, input logic [WIDTH-1:0] d);
      bit    eovf = 0, eunf = 0;
      string tag;
      push = pu; pop = po; din = d;
      if (pu) begin
         if (mptr >= DEPTH) begin mptr = 0; eovf = 1; end
         mdl[mptr] = d;
         mptr++;
         tag = po ? "R6" : (eovf ? "R3" : "R2");
      end else if (po) begin
         if (mptr == 0) begin mptr = DEPTH - 1; eunf = 1; end
         else mptr--;
         mdata = mdl[mptr];
         tag = eunf ? "R5" : "R4";
      end else begin
         tag = "R7";
      end
      @(negedge clk);
      chk(tag, "pointer", int'(sp), mptr);
      chk(tag, "read data", int'(dout), int'(mdata));
      chk(eovf ? "R3" : "R8", "overflow flag", int'(ovf), int'(eovf));
      chk(eunf ? "R5" : "R8", "underflow flag", int'(unf), int'(eunf));
   endtask

   initial begin : main
      logic [15:0] lfsr = 16'hACE1;
      #1;
      @(negedge clk); @(negedge clk);
      // R1: reset state
      chk("R1", "pointer", int'(sp), 0);
      chk("R1", "read data", int'(dout), 0);
      chk("R1", "overflow flag", int'(ovf), 0);
      chk("R1", "underflow flag", int'(unf), 0);
      rst_n = 1'b1;
      @(negedge clk);
      step(0, 0, 16'h0);                       // R7 idle
      for (int i = 0; i < 7; i++) step(1, 0, 16'hA000 + 16'(i)); // R2, 7th is R3
      step(0, 0, 16'h0);                       // R8 flag drops
      step(0, 1, 16'h0);                       // R4 returns entry 0
      step(0, 1, 16'h0);                       // R5 returns entry 5
      step(0, 0, 16'h0);                       // R8 flag drops
      for (int i = 0; i < 5; i++) step(0, 1, 16'h0); // R4 down to 0
      step(0, 1, 16'h0);                       // R5 again
      step(1, 1, 16'hBEEF);                    // R6
      step(0, 1, 16'h0);                       // R4 reads BEEF
      step(1, 1, 16'hC0DE);                    // R6
      step(0, 0, 16'h0);                       // R7
      // pseudo-random sweep
      for (int i = 0; i < 600; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         unique case (lfsr[2:0])
            3'd0, 3'd1, 3'd2: step(1, 0, lfsr ^ 16'h5A5A);
            3'd3, 3'd4, 3'd5: step(0, 1, 16'h0);
            3'd6:             step(1, 1, ~lfsr);
            default:          step(0, 0, lfsr);
         endcase
      end
      push = 0; pop = 0;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : watchdog
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule